// File: doc/BRIEF.md
# MESI Snooping Line Controller

This block keeps the coherence state of a small, direct-mapped set of cache lines for one cache on a shared snooping bus. The processor side issues read, write and evict requests and gets back ready, a hit flag and read data. When a request cannot be served locally, the controller raises a bus request with a command: bus read, read-for-ownership, upgrade or write-back. It holds the processor stalled until an external arbiter grants the bus and reports the transaction done. On the snoop side it watches the commands of the other caches. It drives its term of the wired-OR shared signal and supplies dirty data when it holds the only modified copy.

Each line is in one of four states. Invalid holds no data. Shared is clean, read-only and possibly held by other caches. Exclusive is clean and the only copy. Modified is dirty and the only copy. The controller reads the shared signal when its own bus read completes, and this decides whether the fill lands as Exclusive or as Shared. This lets a private line become writable later without any bus traffic. Addresses split into a low index field, which selects the line, and a high tag field.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid: the first read of any address misses and issues a bus read, and a snooped read sees the shared output low.
- R2: A read that misses issues bus command 1 (read). On completion, the returned data goes to the processor and the line fills as Exclusive if bus_shared_in was low, or as Shared if it was high.
- R3: A write that misses issues command 2 (read-for-ownership). It completes with the line Modified, holding the write data.
- R4: A write to a Shared line issues command 3 (upgrade) and ends Modified. A snooped upgrade (snoop code 2) invalidates a local valid copy.
- R5: A write to an Exclusive line completes at once with hit high, no bus request, and the line Modified.
- R6: A read that hits in Shared, Exclusive or Modified returns the line data with hit high, makes no bus request and leaves the state unchanged.
- R7: A snooped read (snoop code 0) to a Modified line asserts snp_supply with the line data, so memory is updated, and downgrades the line to Shared. A snooped read to an Exclusive line also downgrades it to Shared.
- R8: A snooped read-for-ownership (snoop code 1) invalidates a valid matching line. If that line was Modified, it supplies the data in the same cycle.
- R9: Evicting an Exclusive or Shared line drops it with no bus traffic. Evicting a Modified line issues command 4 (write-back) with the line data and completes when that transfer is done. Evicting an address that is not held changes nothing.
- R10: snp_shared_out is high during a snooped read exactly when a valid line has a matching tag at the snooped index.
- R11: A request that needs the bus keeps cpu_ready low until bus_gnt and bus_done are both high. Each cycle the bus command is recomputed from the line's current state.
- R12: When a snoop targets the same line index as a pending processor request, the snoop update is applied and the processor request does not complete in that cycle.
- R13: A miss whose index holds a Modified line with another tag first writes that line back (command 4, old address) and then issues the fill.

Processor op codes: 0 read, 1 write, 2 evict. The index is cpu_addr[IDX_W-1:0], where IDX_W = log2(LINES).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present, held until cpu_ready |
| cpu_req_op | input | 2 | 0 read, 1 write, 2 evict |
| cpu_addr | input | ADDR_W | Request address (tag above index) |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_hit | output | 1 | Completed without any bus transaction on a held line |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready on a read |
| bus_req | output | 1 | Bus transaction wanted |
| bus_cmd | output | 3 | 0 none, 1 read, 2 read-for-ownership, 3 upgrade, 4 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_gnt | input | 1 | Arbiter grant |
| bus_done | input | 1 | Transaction finishes (meaningful with bus_gnt) |
| bus_rdata | input | DATA_W | Fill data for a read |
| bus_shared_in | input | 1 | Wired-OR shared signal, read at fill completion |
| snp_valid | input | 1 | Snooped command present |
| snp_cmd | input | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 no effect |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared_out | output | 1 | This cache's term of the shared signal |
| snp_supply | output | 1 | Dirty data supplied on snp_data |
| snp_data | output | DATA_W | Data of the snooped line |

## Verification
The bench checks the fill decision in both directions. A design that ignores the shared signal would later issue an upgrade where a silent write is due, or stay quiet where an upgrade is needed. It checks that snooped reads on Exclusive and Modified lines downgrade them, so the next local write must upgrade. It also checks that a conflict miss on a dirty index writes back the old address before the fill, and that evicting a line that is not held has no effect. The hardest case is a snooped read-for-ownership that arrives together with a grant for a pending upgrade. A controller without snoop priority would complete the stale upgrade. A controller that does not re-evaluate would keep asking for an upgrade after its copy is gone, when a read-for-ownership is now needed.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_st_t;
  typedef enum logic [1:0] {OP_RD = 2'd0, OP_WR = 2'd1, OP_EV = 2'd2, OP_NOP = 2'd3} cpu_op_t;
  typedef enum logic [2:0] {BC_NONE = 3'd0, BC_RD = 3'd1, BC_RDX = 3'd2,
                            BC_UPG = 3'd3, BC_WB = 3'd4} bus_cmd_t;
  typedef enum logic [1:0] {SN_RD = 2'd0, SN_RDX = 2'd1, SN_UPG = 2'd2, SN_NONE = 2'd3} snp_cmd_t;

  typedef struct packed {
    logic     need_bus;
    logic     victim;
    bus_cmd_t cmd;
    logic     upd;
    line_st_t nxt;
    logic     fill_rd;
    logic     line_hit;
  } cpu_act_t;

  typedef struct packed {
    logic     hit;
    logic     shared;
    logic     supply;
    logic     upd;
    line_st_t nxt;
  } snp_act_t;

  // Processor-side decision from the line's present state.
  function automatic cpu_act_t cpu_decide(cpu_op_t op, logic tag_eq, line_st_t st, logic shared);
    cpu_act_t a;
    a = '0;
    a.cmd = BC_NONE;
    a.nxt = st;
    a.line_hit = tag_eq && (st != ST_I);
    case (op)
      OP_RD: begin
        if (!a.line_hit) begin
          a.need_bus = 1'b1;
          a.upd      = 1'b1;
          if (st == ST_M) begin
            a.victim = 1'b1;
            a.cmd    = BC_WB;
            a.nxt    = ST_I;
          end else begin
            a.cmd     = BC_RD;
            a.nxt     = shared ? ST_S : ST_E;
            a.fill_rd = 1'b1;
          end
        end
      end
      OP_WR: begin
        a.upd = 1'b1;
        a.nxt = ST_M;
        if (a.line_hit && st == ST_S) begin
          a.need_bus = 1'b1;
          a.cmd      = BC_UPG;
        end else if (!a.line_hit) begin
          a.need_bus = 1'b1;
          if (st == ST_M) begin
            a.victim = 1'b1;
            a.cmd    = BC_WB;
            a.nxt    = ST_I;
          end else begin
            a.cmd = BC_RDX;
          end
        end
      end
      OP_EV: begin
        if (a.line_hit) begin
          a.upd = 1'b1;
          a.nxt = ST_I;
          if (st == ST_M) begin
            a.need_bus = 1'b1;
            a.cmd      = BC_WB;
          end
        end
      end
      default: ;
    endcase
    return a;
  endfunction

  // Snoop-side reaction of one line.
  function automatic snp_act_t snoop_decide(snp_cmd_t c, logic tag_eq, line_st_t st);
    snp_act_t a;
    a = '0;
    a.nxt = st;
    a.hit = tag_eq && (st != ST_I);
    if (a.hit) begin
      case (c)
        SN_RD: begin
          a.shared = 1'b1;
          a.supply = (st == ST_M);
          a.upd    = (st == ST_M) || (st == ST_E);
          a.nxt    = ST_S;
        end
        SN_RDX: begin
          a.supply = (st == ST_M);
          a.upd    = 1'b1;
          a.nxt    = ST_I;
        end
        SN_UPG: begin
          a.upd = 1'b1;
          a.nxt = ST_I;
        end
        default: ;
      endcase
    end
    return a;
  endfunction

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  c_idx,
  input  logic              c_we,
  input  line_st_t          c_st,
  input  logic              c_tag_we,
  input  logic [TAG_W-1:0]  c_tag,
  input  logic              c_data_we,
  input  logic [DATA_W-1:0] c_data,
  output line_st_t          c_st_o,
  output logic [TAG_W-1:0]  c_tag_o,
  output logic [DATA_W-1:0] c_data_o,
  input  logic [IDX_W-1:0]  s_idx,
  input  logic              s_we,
  input  line_st_t          s_st,
  output line_st_t          s_st_o,
  output logic [TAG_W-1:0]  s_tag_o,
  output logic [DATA_W-1:0] s_data_o,
  output logic [2*LINES-1:0] st_flat
);

  line_st_t          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (!rst_n) begin
        st_q[i]   <= ST_I;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end else if (s_we && s_idx == IDX_W'(i)) begin
        st_q[i] <= s_st;
      end else if (c_we && c_idx == IDX_W'(i)) begin
        st_q[i] <= c_st;
        if (c_tag_we)  tag_q[i]  <= c_tag;
        if (c_data_we) data_q[i] <= c_data;
      end
    end
  end

  assign c_st_o   = st_q[c_idx];
  assign c_tag_o  = tag_q[c_idx];
  assign c_data_o = data_q[c_idx];
  assign s_st_o   = st_q[s_idx];
  assign s_tag_o  = tag_q[s_idx];
  assign s_data_o = data_q[s_idx];

  for (genvar g = 0; g < LINES; g++) begin : g_flat
    assign st_flat[2*g +: 2] = st_q[g];
  end

endmodule

// File: rtl/mesi_snoop_port.sv
module mesi_snoop_port
  import mesi_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              snp_valid,
  input  snp_cmd_t          snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  line_st_t          line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              snp_hit,
  output logic              shared_o,
  output logic              supply_o,
  output logic [DATA_W-1:0] data_o,
  output logic              upd_o,
  output line_st_t          nxt_o
);

  snp_act_t act;

  always_comb begin
    act      = snoop_decide(snp_cmd, snp_tag == line_tag, line_st);
    snp_hit  = snp_valid && act.hit;
    shared_o = snp_valid && act.shared;
    supply_o = snp_valid && act.supply;
    upd_o    = snp_valid && act.upd;
    nxt_o    = act.nxt;
    data_o   = line_data;
  end

endmodule

// File: rtl/mesi_cpu_port.sv
module mesi_cpu_port
  import mesi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              req_valid,
  input  cpu_op_t           req_op,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              conflict,
  input  line_st_t          line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  input  logic              bus_gnt,
  input  logic              bus_done,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared_in,
  output logic              ready,
  output logic              hit,
  output logic [DATA_W-1:0] rdata,
  output logic              bus_req,
  output bus_cmd_t          bus_cmd,
  output logic [IDX_W+TAG_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              st_we,
  output line_st_t          st_nxt,
  output logic              tag_we,
  output logic              data_we,
  output logic [DATA_W-1:0] data_nxt,
  output logic              fill_rd
);

  cpu_act_t act;
  logic     xfer;
  logic     step;

  always_comb begin
    act      = cpu_decide(req_op, req_tag == line_tag, line_st, bus_shared_in);
    xfer     = bus_gnt && bus_done;
    step     = req_valid && !conflict && (!act.need_bus || xfer);
    ready    = step && !act.victim;
    hit      = ready && act.line_hit && !act.need_bus;
    rdata    = act.fill_rd ? bus_rdata : line_data;
    bus_req  = req_valid && act.need_bus;
    bus_cmd  = bus_req ? act.cmd : BC_NONE;
    bus_addr = (act.cmd == BC_WB) ? {line_tag, req_idx} : {req_tag, req_idx};
    bus_wdata = line_data;
    st_we    = step && act.upd;
    st_nxt   = act.nxt;
    tag_we   = st_we && (act.cmd == BC_RD || act.cmd == BC_RDX);
    data_we  = st_we && (act.fill_rd || (req_op == OP_WR && !act.victim));
    data_nxt = act.fill_rd ? bus_rdata : req_wdata;
    fill_rd  = step && act.fill_rd;
  end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic [1:0]        cpu_req_op,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_hit,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [2:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              bus_done,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared_out,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  c_idx, s_idx;
  logic [TAG_W-1:0]  c_tag, s_tag;
  line_st_t          c_st, s_st, c_st_nxt, s_st_nxt;
  logic [TAG_W-1:0]  c_line_tag, s_line_tag;
  logic [DATA_W-1:0] c_line_data, s_line_data, c_data_nxt;
  logic              c_we, c_tag_we, c_data_we, s_we;
  bus_cmd_t          cmd_e;
  logic [2*LINES-1:0] st_flat;

  // Named internal events for the checker.
  logic ev_conflict, ev_fill_rd, ev_snp_hit;

  assign c_idx = cpu_addr[IDX_W-1:0];
  assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];
  assign ev_conflict = cpu_req_valid && snp_valid && (s_idx == c_idx);
  assign bus_cmd = cmd_e;

  mesi_line_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .c_idx(c_idx), .c_we(c_we), .c_st(c_st_nxt), .c_tag_we(c_tag_we), .c_tag(c_tag),
    .c_data_we(c_data_we), .c_data(c_data_nxt),
    .c_st_o(c_st), .c_tag_o(c_line_tag), .c_data_o(c_line_data),
    .s_idx(s_idx), .s_we(s_we), .s_st(s_st_nxt),
    .s_st_o(s_st), .s_tag_o(s_line_tag), .s_data_o(s_line_data),
    .st_flat(st_flat)
  );

  mesi_snoop_port #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid(snp_valid), .snp_cmd(snp_cmd_t'(snp_cmd)), .snp_tag(s_tag),
    .line_st(s_st), .line_tag(s_line_tag), .line_data(s_line_data),
    .snp_hit(ev_snp_hit), .shared_o(snp_shared_out), .supply_o(snp_supply),
    .data_o(snp_data), .upd_o(s_we), .nxt_o(s_st_nxt)
  );

  mesi_cpu_port #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_cpu (
    .req_valid(cpu_req_valid), .req_op(cpu_op_t'(cpu_req_op)), .req_idx(c_idx),
    .req_tag(c_tag), .req_wdata(cpu_wdata), .conflict(ev_conflict),
    .line_st(c_st), .line_tag(c_line_tag), .line_data(c_line_data),
    .bus_gnt(bus_gnt), .bus_done(bus_done), .bus_rdata(bus_rdata),
    .bus_shared_in(bus_shared_in),
    .ready(cpu_ready), .hit(cpu_hit), .rdata(cpu_rdata),
    .bus_req(bus_req), .bus_cmd(cmd_e), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .st_we(c_we), .st_nxt(c_st_nxt), .tag_we(c_tag_we), .data_we(c_data_we),
    .data_nxt(c_data_nxt), .fill_rd(ev_fill_rd)
  );

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk
  import mesi_pkg::*;
#(
  parameter int LINES = 4,
  parameter int IDX_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_req_valid,
  input logic [1:0]         cpu_req_op,
  input logic               cpu_ready,
  input logic               cpu_hit,
  input logic               bus_req,
  input logic [2:0]         bus_cmd,
  input logic               bus_shared_in,
  input logic               snp_valid,
  input logic [1:0]         snp_cmd,
  input logic               snp_supply,
  input logic               ev_conflict,
  input logic               ev_fill_rd,
  input logic               ev_snp_hit,
  input logic [IDX_W-1:0]   c_idx,
  input logic [IDX_W-1:0]   s_idx,
  input logic [2*LINES-1:0] st_flat
);

  logic [IDX_W-1:0] c_idx_q, s_idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_idx_q <= '0;
      s_idx_q <= '0;
    end else begin
      c_idx_q <= c_idx;
      s_idx_q <= s_idx;
    end
  end

  function automatic logic [1:0] st_at(logic [2*LINES-1:0] f, logic [IDX_W-1:0] i);
    return f[2*i +: 2];
  endfunction

  p_fill_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_rd && !bus_shared_in |=> st_at(st_flat, c_idx_q) == ST_E);
  p_fill_shared_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_rd && bus_shared_in |=> st_at(st_flat, c_idx_q) == ST_S);
  p_write_ends_mod_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_ready && cpu_req_op == OP_WR |=> st_at(st_flat, c_idx_q) == ST_M);
  p_hit_no_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && cpu_hit |-> !bus_req);
  p_supply_from_mod_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> st_at(st_flat, s_idx) == ST_M);
  p_rdx_invalidates_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_snp_hit && snp_cmd == SN_RDX |=> st_at(st_flat, s_idx_q) == ST_I);
  p_req_has_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_cmd != BC_NONE);
  p_snoop_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ev_conflict |-> !cpu_ready);

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.LINES(LINES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req_valid(cpu_req_valid), .cpu_req_op(cpu_req_op),
  .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .bus_req(bus_req), .bus_cmd(bus_cmd),
  .bus_shared_in(bus_shared_in), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
  .snp_supply(snp_supply), .ev_conflict(ev_conflict), .ev_fill_rd(ev_fill_rd),
  .ev_snp_hit(ev_snp_hit), .c_idx(c_idx), .s_idx(s_idx), .st_flat(st_flat)
);

// File: tb/mesi_line_ctrl_bench.sv
`timescale 1ns/1ps
module mesi_line_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0;
  logic [1:0]  cpu_req_op = 2'd0;
  logic [7:0]  cpu_addr = 8'd0;
  logic [31:0] cpu_wdata = 32'd0;
  logic        cpu_ready, cpu_hit;
  logic [31:0] cpu_rdata;
  logic        bus_req;
  logic [2:0]  bus_cmd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_gnt = 1'b0, bus_done = 1'b0, bus_shared_in = 1'b0;
  logic [31:0] bus_rdata = 32'd0;
  logic        snp_valid = 1'b0;
  logic [1:0]  snp_cmd = 2'd3;
  logic [7:0]  snp_addr = 8'd0;
  logic        snp_shared_out, snp_supply;
  logic [31:0] snp_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  mesi_line_ctrl u_mesi_line_ctrl (.*);

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] wd;
    logic        sh;
    logic [31:0] fill;
    logic [2:0]  c1;
    logic [2:0]  c2;
    logic        hit;
    logic        chk_rd;
    logic [31:0] rd;
    logic [31:0] wb;
    logic [3:0]  rq;
  } vec_t;

  // op: 0 rd 1 wr 2 ev; cmd: 0 none 1 rd 2 rdx 3 upg 4 wb
  localparam vec_t VEC [15] = '{
    '{2'd0, 8'h10, 32'h0, 1'b0, 32'hAAAA0001, 3'd1, 3'd0, 1'b0, 1'b1, 32'hAAAA0001, 32'h0, 4'd2},  // R2 fill E
    '{2'd1, 8'h10, 32'h11110000, 1'b0, 32'h0, 3'd0, 3'd0, 1'b1, 1'b0, 32'h0, 32'h0, 4'd5},         // R5 silent
    '{2'd0, 8'h10, 32'h0, 1'b0, 32'h0, 3'd0, 3'd0, 1'b1, 1'b1, 32'h11110000, 32'h0, 4'd6},         // R6
    '{2'd0, 8'h21, 32'h0, 1'b1, 32'hBBBB0002, 3'd1, 3'd0, 1'b0, 1'b1, 32'hBBBB0002, 32'h0, 4'd2},  // R2 fill S
    '{2'd1, 8'h21, 32'h22220000, 1'b0, 32'h0, 3'd3, 3'd0, 1'b0, 1'b0, 32'h0, 32'h0, 4'd4},         // R4
    '{2'd0, 8'h21, 32'h0, 1'b0, 32'h0, 3'd0, 3'd0, 1'b1, 1'b1, 32'h22220000, 32'h0, 4'd6},         // R6
    '{2'd1, 8'h32, 32'h33330000, 1'b0, 32'h0, 3'd2, 3'd0, 1'b0, 1'b0, 32'h0, 32'h0, 4'd3},         // R3
    '{2'd0, 8'h32, 32'h0, 1'b0, 32'h0, 3'd0, 3'd0, 1'b1, 1'b1, 32'h33330000, 32'h0, 4'd3},         // R3 data
    '{2'd0, 8'h14, 32'h0, 1'b0, 32'hCCCC0003, 3'd4, 3'd1, 1'b0, 1'b1, 32'hCCCC0003, 32'h11110000, 4'd13}, // R13
    '{2'd2, 8'h14, 32'h0, 1'b0, 32'h0, 3'd0, 3'd0, 1'b1, 1'b0, 32'h0, 32'h0, 4'd9},                // R9 evict E
    '{2'd0, 8'h14, 32'h0, 1'b1, 32'hDDDD0004, 3'd1, 3'd0, 1'b0, 1'b1, 32'hDDDD0004, 32'h0, 4'd9},  // R9 gone
    '{2'd2, 8'h32, 32'h0, 1'b0, 32'h0, 3'd4, 3'd0, 1'b0, 1'b0, 32'h0, 32'h33330000, 4'd9},         // R9 evict M
    '{2'd0, 8'h32, 32'h0, 1'b0, 32'hEEEE0005, 3'd1, 3'd0, 1'b0, 1'b1, 32'hEEEE0005, 32'h0, 4'd9},  // R9 refetch
    '{2'd2, 8'h3A, 32'h0, 1'b0, 32'h0, 3'd0, 3'd0, 1'b0, 1'b0, 32'h0, 32'h0, 4'd9},                // R9 absent
    '{2'd0, 8'h32, 32'h0, 1'b0, 32'h0, 3'd0, 3'd0, 1'b1, 1'b1, 32'hEEEE0005, 32'h0, 4'd9}          // R9 kept
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_op(input logic [1:0] op, input logic [7:0] addr, input logic [31:0] wd,
                        input logic sh, input logic [31:0] fill,
                        output logic [2:0] c1, output logic [2:0] c2, output logic hit,
                        output logic [31:0] rd, output logic [31:0] wbd, output logic ok);
    int n = 0;
    c1 = 3'd0; c2 = 3'd0; hit = 1'b0; rd = 32'd0; wbd = 32'd0; ok = 1'b0;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_op = op; cpu_addr = addr; cpu_wdata = wd;
    while (!ok && n < 20) begin
      #1;
      if (bus_req) begin
        if (c1 == 3'd0) c1 = bus_cmd; else c2 = bus_cmd;
        if (bus_cmd == 3'd4) wbd = bus_wdata;
        bus_gnt = 1'b1; bus_done = 1'b1; bus_rdata = fill; bus_shared_in = sh;
        #1;
      end
      if (cpu_ready) begin
        hit = cpu_hit; rd = cpu_rdata; ok = 1'b1;
      end
      @(negedge clk);
      bus_gnt = 1'b0; bus_done = 1'b0;
      n++;
    end
    cpu_req_valid = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [7:0] addr,
                       output logic sh, output logic sup, output logic [31:0] d);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = cmd; snp_addr = addr;
    #1;
    sh = snp_shared_out; sup = snp_supply; d = snp_data;
    @(negedge clk);
    snp_valid = 1'b0; snp_cmd = 2'd3;
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [2:0] c1, c2;
    logic h, ok, sh, sup;
    logic [31:0] rd, wbd, d;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 idle bus_req", {31'd0, bus_req}, 32'd0);
    snoop(2'd0, 8'h10, sh, sup, d);
    chk("R1 snoop after reset shared", {31'd0, sh}, 32'd0);

    for (int i = 0; i < 15; i++) begin
      cpu_op(VEC[i].op, VEC[i].addr, VEC[i].wd, VEC[i].sh, VEC[i].fill, c1, c2, h, rd, wbd, ok);
      chk($sformatf("R%0d row %0d done", VEC[i].rq, i), {31'd0, ok}, 32'd1);
      chk($sformatf("R%0d row %0d cmd1", VEC[i].rq, i), {29'd0, c1}, {29'd0, VEC[i].c1});
      chk($sformatf("R%0d row %0d cmd2", VEC[i].rq, i), {29'd0, c2}, {29'd0, VEC[i].c2});
      chk($sformatf("R%0d row %0d hit", VEC[i].rq, i), {31'd0, h}, {31'd0, VEC[i].hit});
      if (VEC[i].chk_rd) chk($sformatf("R%0d row %0d rdata", VEC[i].rq, i), rd, VEC[i].rd);
      if (VEC[i].c1 == 3'd4) chk($sformatf("R%0d row %0d wb data", VEC[i].rq, i), wbd, VEC[i].wb);
    end

    // R10 / R7: snooped read on E line 0x32 -> shared, no supply, becomes S
    snoop(2'd0, 8'h32, sh, sup, d);
    chk("R10 shared on E", {31'd0, sh}, 32'd1);
    chk("R7 no supply on E", {31'd0, sup}, 32'd0);
    cpu_op(2'd1, 8'h32, 32'h66660000, 1'b0, 32'h0, c1, c2, h, rd, wbd, ok);
    chk("R7 E downgraded so upgrade", {29'd0, c1}, 32'd3);

    // R7: snooped read on M line supplies and downgrades
    snoop(2'd0, 8'h32, sh, sup, d);
    chk("R7 supply on M", {31'd0, sup}, 32'd1);
    chk("R7 supplied data", d, 32'h66660000);
    cpu_op(2'd1, 8'h32, 32'h77770000, 1'b0, 32'h0, c1, c2, h, rd, wbd, ok);
    chk("R7 M downgraded so upgrade", {29'd0, c1}, 32'd3);

    // R8: snooped read-for-ownership on M supplies and invalidates
    snoop(2'd1, 8'h32, sh, sup, d);
    chk("R8 supply on rdx", {31'd0, sup}, 32'd1);
    chk("R8 rdx data", d, 32'h77770000);
    cpu_op(2'd0, 8'h32, 32'h0, 1'b0, 32'h88880000, c1, c2, h, rd, wbd, ok);
    chk("R8 invalidated so read miss", {29'd0, c1}, 32'd1);

    // R4: snooped upgrade invalidates S line 0x14
    snoop(2'd2, 8'h14, sh, sup, d);
    cpu_op(2'd0, 8'h14, 32'h0, 1'b0, 32'h99990000, c1, c2, h, rd, wbd, ok);
    chk("R4 snooped upgrade invalidated", {29'd0, c1}, 32'd1);

    // R10: no match
    snoop(2'd0, 8'h3B, sh, sup, d);
    chk("R10 empty index shared", {31'd0, sh}, 32'd0);
    snoop(2'd0, 8'h25, sh, sup, d);
    chk("R10 tag mismatch shared", {31'd0, sh}, 32'd0);
    chk("R10 tag mismatch supply", {31'd0, sup}, 32'd0);

    // R11 / R12: stall, snoop priority, re-evaluation
    snoop(2'd0, 8'h14, sh, sup, d);
    chk("R7 E line seen shared", {31'd0, sh}, 32'd1);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_op = 2'd1; cpu_addr = 8'h14; cpu_wdata = 32'hABCD0000;
    #1;
    chk("R11 upgrade requested", {29'd0, bus_cmd}, 32'd3);
    chk("R11 stalled without grant", {31'd0, cpu_ready}, 32'd0);
    @(negedge clk);
    #1;
    chk("R11 still stalled", {31'd0, cpu_ready}, 32'd0);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 8'h14;
    bus_gnt = 1'b1; bus_done = 1'b1; bus_shared_in = 1'b0;
    #1;
    chk("R12 snoop wins same line", {31'd0, cpu_ready}, 32'd0);
    @(negedge clk);
    snp_valid = 1'b0; snp_cmd = 2'd3; bus_gnt = 1'b0; bus_done = 1'b0;
    #1;
    chk("R11 re-evaluated to rdx", {29'd0, bus_cmd}, 32'd2);
    bus_gnt = 1'b1; bus_done = 1'b1;
    #1;
    chk("R11 completes on grant", {31'd0, cpu_ready}, 32'd1);
    @(negedge clk);
    bus_gnt = 1'b0; bus_done = 1'b0; cpu_req_valid = 1'b0;
    cpu_op(2'd0, 8'h14, 32'h0, 1'b0, 32'h0, c1, c2, h, rd, wbd, ok);
    chk("R3 written data after rdx", rd, 32'hABCD0000);
    chk("R6 hit after rdx", {31'd0, h}, 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule